// File: doc/BRIEF.md
# Configuration-Clear Line Controller

This block drives the active-low clear line that wipes the configuration of a reconfigurable device so that a new bitstream can be loaded. Three things can pull the line low. The first is a processor write strobe decoded at one fixed address. The second is an over-temperature request from a housekeeping controller. The third is a three-position strap that selects how the line behaves: it can pass the requests through, hold the line low, or block the line.

A build parameter selects an override policy. With the override on, an over-temperature request clears the device in every strap position, including the blocking one. A processor write does not act as a bare strobe. It starts a clear pulse that lasts a fixed number of clock cycles, set by a parameter, so the target always sees a valid pulse width. Each asynchronous input passes through a two-flop synchroniser.

The block also watches the device's configuration-done input. It drives a status LED that is lit while the device is unconfigured, and it presents a status bit that software can poll to wait for configuration to finish. A sticky flag records that an over-temperature clear has happened. It stays set until software clears it with a write to a second address, so the cause of an unexpected reconfiguration can be read back later.

Top module: `cfgclr_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, `prog_n_o` is 1, `led_o` is 1, and both `done_stat_o` and `ot_flag_o` are 0.
- R2: With strap normal (`strap_i` = 2'b00) and no over-temperature, a strobe whose address equals `CLR_ADDR` drives `prog_n_o` low. The low starts on the second rising edge after the strobe's edge, counting that edge as the first. It lasts exactly `PULSE_LEN` cycles and then the line returns high.
- R3: A strobe at any address other than `CLR_ADDR`, including `FLAG_ADDR`, leaves `prog_n_o` high.
- R4: With strap normal, an over-temperature input held high drives `prog_n_o` low on the third rising edge after the input changes, and not before.
- R5: With strap forced (`strap_i` = 2'b01), `prog_n_o` stays low whatever the write and over-temperature inputs do.
- R6: With strap disabled (`strap_i` = 2'b10) and `OT_OVERRIDE` = 0, `prog_n_o` never goes low, whether a write or an over-temperature request arrives.
- R7: With `OT_OVERRIDE` = 1, an over-temperature request drives `prog_n_o` low in every strap position, including disabled. Writes still follow the strap.
- R8: `led_o` is the inverse of the configuration-done input, delayed by three rising edges. It is lit (1) while the device is unconfigured.
- R9: `done_stat_o` follows the configuration-done input with the same three-edge delay.
- R10: `ot_flag_o` sets once the synchronised over-temperature input is high, and it stays set after the input drops. A strobe at `FLAG_ADDR` clears it on that edge. If the over-temperature input is still high, setting wins over clearing.
- R11: Strap code 2'b11 behaves exactly like disabled.
- R12: A new `CLR_ADDR` strobe during a clear pulse restarts the count, so the line stays low for `PULSE_LEN` cycles after the last strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Processor write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Address of the write |
| strap_i | input | 2 | Strap position: 00 normal, 01 forced, 10 or 11 disabled (asynchronous) |
| ot_req_i | input | 1 | Over-temperature clear request (asynchronous) |
| cfg_done_i | input | 1 | Configuration-done from the target device (asynchronous) |
| prog_n_o | output | 1 | Active-low configuration-clear line |
| led_o | output | 1 | Status LED, 1 = lit while unconfigured |
| done_stat_o | output | 1 | Pollable configuration-done status |
| ot_flag_o | output | 1 | Sticky over-temperature-clear flag |

## Verification
The merge logic is swept over every strap code, with the over-temperature input on and off and with and without a clear write. Two copies of the block are built, one with the override on and one with it off. The sweep therefore separates a strap that blocks a source from one that forces the line, and the blocking strap from its override, and it shows that code 11 matches code 10. The pulse length is measured both for a single write and for a write that lands inside a running pulse, which separates a fixed-length pulse from a retriggered one. Writes to the flag address and to an unrelated address show that the decode ignores them. The over-temperature path is sampled one edge before and on the edge where the line must fall, which pins the synchroniser latency. The sticky flag is tested for set, hold, clear, and set winning over clear.

// File: rtl/cfgclr_pkg.sv
package cfgclr_pkg;

  typedef enum logic [1:0] {
    STRAP_NORMAL  = 2'b00,
    STRAP_FORCE   = 2'b01,
    STRAP_OFF     = 2'b10,
    STRAP_OFF_ALT = 2'b11
  } strap_e;

  localparam int SYNC_STAGES = 2;

endpackage

// File: rtl/cfgclr_sync.sv
module cfgclr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          stage_q[g] <= '0;
        end else if (g == 0) begin
          stage_q[g] <= d_i;
        end else begin
          stage_q[g] <= stage_q[(g > 0) ? g - 1 : 0];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/cfgclr_pulse.sv
module cfgclr_pulse #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic hit_i,
  output logic busy_o
);

  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(LEN);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (hit_i) begin
      cnt_q <= LOAD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign busy_o = (cnt_q != '0);

  AST_PULSE_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !hit_i) |=> (cnt_q == $past(cnt_q) - CW'(1))); // R2

  AST_PULSE_RETRIGGER: assert property (@(posedge clk) disable iff (rst)
    hit_i |=> (busy_o && cnt_q == LOAD)); // R12

  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LOAD); // R2

endmodule

// File: rtl/cfgclr_merge.sv
module cfgclr_merge
  import cfgclr_pkg::*;
#(
  parameter bit OT_OVERRIDE = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] strap_i,
  input  logic       ot_i,
  input  logic       wr_busy_i,
  output logic       prog_n_o
);

  logic strap_req;
  logic clear_req;

  always_comb begin
    unique case (strap_i)
      STRAP_NORMAL: strap_req = ot_i | wr_busy_i;
      STRAP_FORCE:  strap_req = 1'b1;
      default:      strap_req = 1'b0;
    endcase
  end

  generate
    if (OT_OVERRIDE) begin : g_ot_override
      assign clear_req = strap_req | ot_i;
    end else begin : g_strap_only
      assign clear_req = strap_req;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_n_o <= 1'b1;
    end else begin
      prog_n_o <= ~clear_req;
    end
  end

  AST_FORCED_LOW: assert property (@(posedge clk) disable iff (rst)
    (strap_i == STRAP_FORCE) |=> !prog_n_o); // R5

  AST_OFF_HIGH: assert property (@(posedge clk) disable iff (rst)
    (strap_i[1] && !(OT_OVERRIDE && ot_i)) |=> prog_n_o); // R6

  AST_OT_LOW: assert property (@(posedge clk) disable iff (rst)
    (ot_i && (OT_OVERRIDE || strap_i == STRAP_NORMAL)) |=> !prog_n_o); // R7

  AST_WRITE_LOW: assert property (@(posedge clk) disable iff (rst)
    (wr_busy_i && strap_i == STRAP_NORMAL) |=> !prog_n_o); // R2

endmodule

// File: rtl/cfgclr_status.sv
module cfgclr_status (
  input  logic clk,
  input  logic rst,
  input  logic done_i,
  input  logic ot_i,
  input  logic flag_clr_i,
  output logic led_o,
  output logic done_stat_o,
  output logic ot_flag_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      led_o       <= 1'b1;
      done_stat_o <= 1'b0;
    end else begin
      led_o       <= ~done_i;
      done_stat_o <= done_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ot_flag_o <= 1'b0;
    end else if (ot_i) begin
      ot_flag_o <= 1'b1;
    end else if (flag_clr_i) begin
      ot_flag_o <= 1'b0;
    end
  end

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ot_flag_o && !flag_clr_i) |=> ot_flag_o); // R10

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    ot_i |=> ot_flag_o); // R10

  AST_LED_DARK: assert property (@(posedge clk) disable iff (rst)
    done_i |=> (!led_o && done_stat_o)); // R8

endmodule

// File: rtl/cfgclr_ctrl.sv
module cfgclr_ctrl
  import cfgclr_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          PULSE_LEN   = 8,
  parameter bit          OT_OVERRIDE = 1'b0,
  parameter logic [15:0] CLR_ADDR    = 16'h0100,
  parameter logic [15:0] FLAG_ADDR   = 16'h0104
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        strap_i,
  input  logic              ot_req_i,
  input  logic              cfg_done_i,
  output logic              prog_n_o,
  output logic              led_o,
  output logic              done_stat_o,
  output logic              ot_flag_o
);

  localparam int SW = 4;

  logic [SW-1:0] raw_in;
  logic [SW-1:0] syn_in;
  logic [1:0]    strap_s;
  logic          ot_s;
  logic          done_s;
  logic          clr_hit;
  logic          flag_hit;
  logic          wr_busy;

  assign raw_in = {cfg_done_i, ot_req_i, strap_i};

  cfgclr_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_in),
    .q_o (syn_in)
  );

  assign strap_s = syn_in[1:0];
  assign ot_s    = syn_in[2];
  assign done_s  = syn_in[3];

  assign clr_hit  = wr_stb && (wr_addr == ADDR_W'(CLR_ADDR));
  assign flag_hit = wr_stb && (wr_addr == ADDR_W'(FLAG_ADDR));

  cfgclr_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk    (clk),
    .rst    (rst),
    .hit_i  (clr_hit),
    .busy_o (wr_busy)
  );

  cfgclr_merge #(.OT_OVERRIDE(OT_OVERRIDE)) u_merge (
    .clk       (clk),
    .rst       (rst),
    .strap_i   (strap_s),
    .ot_i      (ot_s),
    .wr_busy_i (wr_busy),
    .prog_n_o  (prog_n_o)
  );

  cfgclr_status u_status (
    .clk         (clk),
    .rst         (rst),
    .done_i      (done_s),
    .ot_i        (ot_s),
    .flag_clr_i  (flag_hit),
    .led_o       (led_o),
    .done_stat_o (done_stat_o),
    .ot_flag_o   (ot_flag_o)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> (prog_n_o && led_o && !ot_flag_o)); // R1

  AST_LED_MATCH: assert property (@(posedge clk) disable iff (rst)
    (led_o != done_stat_o)); // R9

endmodule

// File: tb/cfgclr_ctrl_test.sv
`timescale 1ns/1ps
module cfgclr_ctrl_test;

  localparam int          L     = 5;
  localparam logic [15:0] A_CLR = 16'h0100;
  localparam logic [15:0] A_FLG = 16'h0104;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_stb = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [1:0]  strap = 2'b00;
  logic        ot = 1'b0;
  logic        done = 1'b0;
  logic        prog_n, led, dstat, oflag;
  logic        prog_n_v, led_v, dstat_v, oflag_v;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cfgclr_ctrl #(.ADDR_W(16), .PULSE_LEN(L), .OT_OVERRIDE(1'b0),
                .CLR_ADDR(A_CLR), .FLAG_ADDR(A_FLG)) uut (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .strap_i(strap), .ot_req_i(ot), .cfg_done_i(done),
    .prog_n_o(prog_n), .led_o(led), .done_stat_o(dstat), .ot_flag_o(oflag));

  cfgclr_ctrl #(.ADDR_W(16), .PULSE_LEN(L), .OT_OVERRIDE(1'b1),
                .CLR_ADDR(A_CLR), .FLAG_ADDR(A_FLG)) uut_ov (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .strap_i(strap), .ot_req_i(ot), .cfg_done_i(done),
    .prog_n_o(prog_n_v), .led_o(led_v), .done_stat_o(dstat_v), .ot_flag_o(oflag_v));

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(input logic [15:0] a);
    wr_addr = a;
    wr_stb  = 1'b1;
    @(negedge clk);
    wr_stb  = 1'b0;
    wr_addr = '0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    int n;
    int el;
    int el_v;
    settle(3);
    check("R1 prog_n in reset", prog_n, 1);
    check("R1 led in reset", led, 1);
    rst = 1'b0;
    @(negedge clk);
    check("R1 prog_n after reset", prog_n, 1);
    check("R1 led after reset", led, 1);
    check("R1 done_stat after reset", dstat, 0);
    check("R1 ot_flag after reset", oflag, 0);

    // R2: single pulse length
    write(A_CLR);
    check("R2 no low on strobe edge", prog_n, 1);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!prog_n) n++;
      else if (n > 0) break;
    end
    check("R2 pulse length", n, L);
    settle(3);

    // R3: other addresses
    write(A_FLG);
    write(16'h0200);
    n = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!prog_n) n++;
    end
    check("R3 other addresses ignored", n, 0);

    // R12: retrigger
    write(A_CLR);
    settle(2);
    write(A_CLR);
    check("R12 low at retrigger", prog_n, 0);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!prog_n) n++;
      else break;
    end
    check("R12 remaining low after retrigger", n, L);
    settle(3);

    // R4: latency of over-temperature path
    ot = 1'b1;
    settle(2);
    check("R4 not low before third edge", prog_n, 1);
    settle(1);
    check("R4 low on third edge", prog_n, 0);
    ot = 1'b0;
    settle(4);
    check("R4 released", prog_n, 1);

    // R5 R6 R7 R11: sweep strap x ot x write
    for (int s = 0; s < 4; s++) begin
      for (int o = 0; o < 2; o++) begin
        for (int w = 0; w < 2; w++) begin
          strap = 2'(s);
          ot = o[0];
          settle(5);
          if (w != 0) write(A_CLR);
          @(negedge clk);
          if (s == 1) el = 1;
          else if (s == 0) el = (o != 0 || w != 0) ? 1 : 0;
          else el = 0;
          el_v = (el != 0 || o != 0) ? 1 : 0;
          check($sformatf("R5 R6 R11 strap=%0d ot=%0d wr=%0d", s, o, w), prog_n, el ? 0 : 1);
          check($sformatf("R7 override strap=%0d ot=%0d wr=%0d", s, o, w), prog_n_v, el_v ? 0 : 1);
          ot = 1'b0;
          strap = 2'b00;
          settle(L + 6);
        end
      end
    end

    // R8 R9: done tracking
    done = 1'b1;
    settle(2);
    check("R8 led before third edge", led, 1);
    settle(1);
    check("R8 led dark when configured", led, 0);
    check("R9 done status set", dstat, 1);
    done = 1'b0;
    settle(3);
    check("R8 led lit when unconfigured", led, 1);
    check("R9 done status clear", dstat, 0);

    // R10: sticky flag
    write(A_FLG);
    settle(1);
    check("R10 flag cleared", oflag, 0);
    ot = 1'b1;
    settle(4);
    check("R10 flag set", oflag, 1);
    ot = 1'b0;
    settle(4);
    check("R10 flag sticky", oflag, 1);
    write(A_FLG);
    check("R10 flag cleared by write", oflag, 0);
    ot = 1'b1;
    settle(4);
    write(A_FLG);
    check("R10 set wins over clear", oflag, 1);
    ot = 1'b0;
    settle(4);
    write(A_FLG);
    check("R10 final clear", oflag, 0);

    summary();
  end

endmodule